// File: doc/BRIEF.md
# Slot-Timed Half-Duplex Bus Node

This block is one peripheral node on a synchronous serial bus that has no select line. The master always drives a bus clock that idles low. All nodes share one data line. Every packet has a fixed length. The master first broadcasts a command burst: one group of command bytes per node, then a check byte. After that, each node in turn drives the shared line with its report bytes and a check byte of its own. The node oversamples the bus clock and the data line in its system clock domain. It deserializes bytes on the falling bus-clock edge, MSB first, and counts bytes from the start of the packet. From that count alone it finds its command group and its reply window.

Command bytes go to a parallel output, with a one-cycle strobe, only after the broadcast check byte matches. The check is a running code. It starts at 0xAA, and each byte d updates it to ((code XOR d) * 167 + 59) mod 256. A packet that fails the check is dropped silently. In the reply window the node drives the line and raises an output enable. The line is tri-stated at all other times. When the bus clock stays low for two byte times (16 bit periods), the node treats the packet as ended and clears all framing state.

Top module: `sbus_node`

## Requirements
- R1: After reset, sdo_oe_o, sdo_o, cmd_valid_o and cmd_o are all zero.
- R2: Data is sampled on each falling bus-clock edge, MSB first. Bytes are numbered from 0 at the packet start. Broadcast bytes NODE_IDX*CMD_BYTES through NODE_IDX*CMD_BYTES+CMD_BYTES-1 are this node's commands. The first of them lands in the most significant byte of cmd_o.
- R3: The check code starts at 0xAA and updates as ((code ^ d) * 167 + 59) mod 256 over broadcast bytes 0 to N_NODES*CMD_BYTES-1. If byte N_NODES*CMD_BYTES equals the code, cmd_o takes the captured commands and cmd_valid_o pulses high for exactly one system cycle.
- R4: If the broadcast check byte does not match, cmd_valid_o stays low and cmd_o keeps its previous value.
- R5: sdo_oe_o is high exactly for bytes W to W+RPT_BYTES, where W = N_NODES*CMD_BYTES+1+NODE_IDX*(RPT_BYTES+1). It is low for every other byte. sdo_o is low whenever sdo_oe_o is low.
- R6: In the window, sdo_o changes only after a rising bus-clock edge and sends bytes MSB first. The report bytes come from rpt_i, most significant byte first.
- R7: The last window byte is the check code of R3, computed over the RPT_BYTES report bytes sent.
- R8: A bus clock held low for EOP_BITS*BIT_CYC system cycles ends the packet. sdo_oe_o drops, and the next bit received is bit 7 of byte 0.
- R9: A low period of 10 bit periods inside a packet does not disturb byte counting, command capture or the check.
- R10: rpt_i is sampled at the first bit of the window. Changes to it later in the window do not affect the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Bus clock from the master, asynchronous |
| sdi_i | input | 1 | Shared bus data line, as received |
| rpt_i | input | 8*RPT_BYTES | Report bytes to send in this node's window |
| sdo_o | output | 1 | Data driven toward the bus |
| sdo_oe_o | output | 1 | Drive enable for sdo_o; low means tri-stated |
| cmd_o | output | 8*CMD_BYTES | Last confirmed command bytes |
| cmd_valid_o | output | 1 | One-cycle strobe when cmd_o is updated |

## Verification
The end-of-packet strobe and the reply-window drive logic can act in the same cycle. When the strobe fires during a truncated packet, the byte counter still points inside the node's window, so the window enable and the framing reset meet in that cycle and the reset must win. The bench provokes this by stopping the bus clock just after the first window byte and holding it low past the threshold. It then checks that the enable is released. A following full packet must frame, confirm and reply correctly from byte 0.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam logic [7:0] CHK_INIT = 8'hAA;
  localparam logic [7:0] CHK_MUL  = 8'd167;
  localparam logic [7:0] CHK_ADD  = 8'd59;

  // odd multiplier keeps the byte map a permutation
  function automatic logic [7:0] chk_step(input logic [7:0] code, input logic [7:0] data);
    logic [7:0] x;
    x = code ^ data;
    return x * CHK_MUL + CHK_ADD;
  endfunction
endpackage

// File: rtl/sbus_sync_edge.sv
module sbus_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sclk_o,
  output logic sdi_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0]   sclk_q;
  logic [STAGES-1:0] sdi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      sdi_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[STAGES-1:0], sclk_i};
      sdi_q  <= {sdi_q[STAGES-2:0], sdi_i};
    end
  end

  assign sclk_o = sclk_q[STAGES-1];
  assign sdi_o  = sdi_q[STAGES-1];
  assign rise_o = sclk_q[STAGES-1] & ~sclk_q[STAGES];
  assign fall_o = ~sclk_q[STAGES-1] & sclk_q[STAGES];
endmodule

// File: rtl/sbus_eop_det.sv
module sbus_eop_det #(
  parameter int LIMIT = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic eop_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  // starts saturated: no strobe until the clock has been seen high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LIM;
      eop_o <= 1'b0;
    end else begin
      eop_o <= 1'b0;
      if (sclk_i) begin
        cnt_q <= '0;
      end else if (cnt_q != LIM) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LIM - 1'b1) eop_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbus_framer.sv
module sbus_framer #(
  parameter int BYTE_MAX = 32,
  localparam int BW = $clog2(BYTE_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          fall_i,
  input  logic          sdi_i,
  output logic [2:0]    bit_idx_o,
  output logic [BW-1:0] byte_cnt_o,
  output logic          done_o,
  output logic [BW-1:0] done_idx_o,
  output logic [7:0]    byte_o
);
  localparam logic [BW-1:0] MAX_T = BW'(BYTE_MAX);

  logic [6:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      bit_idx_o  <= '0;
      byte_cnt_o <= '0;
      done_o     <= 1'b0;
      done_idx_o <= '0;
      byte_o     <= '0;
    end else if (clr_i) begin
      sh_q       <= '0;
      bit_idx_o  <= '0;
      byte_cnt_o <= '0;
      done_o     <= 1'b0;
      done_idx_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (fall_i) begin
        sh_q      <= {sh_q[5:0], sdi_i};
        bit_idx_o <= bit_idx_o + 3'd1;
        if (bit_idx_o == 3'd7) begin
          done_o     <= 1'b1;
          byte_o     <= {sh_q, sdi_i};
          done_idx_o <= byte_cnt_o;
          if (byte_cnt_o != MAX_T) byte_cnt_o <= byte_cnt_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sbus_node.sv
module sbus_node
  import sbus_pkg::*;
#(
  parameter int N_NODES   = 4,
  parameter int CMD_BYTES = 4,
  parameter int RPT_BYTES = 4,
  parameter int NODE_IDX  = 0,
  parameter int BIT_CYC   = 100,
  parameter int EOP_BITS  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   sdi_i,
  input  logic [8*RPT_BYTES-1:0] rpt_i,
  output logic                   sdo_o,
  output logic                   sdo_oe_o,
  output logic [8*CMD_BYTES-1:0] cmd_o,
  output logic                   cmd_valid_o
);
  localparam int BCAST  = N_NODES * CMD_BYTES;
  localparam int TOT    = BCAST + 1 + N_NODES * (RPT_BYTES + 1);
  localparam int BW     = $clog2(TOT + 1);
  localparam int CMD_LO = NODE_IDX * CMD_BYTES;
  localparam int WIN_S  = BCAST + 1 + NODE_IDX * (RPT_BYTES + 1);
  localparam logic [BW-1:0] BCAST_T  = BW'(BCAST);
  localparam logic [BW-1:0] CMD_LO_T = BW'(CMD_LO);
  localparam logic [BW-1:0] WIN_S_T  = BW'(WIN_S);
  localparam logic [BW-1:0] K_T      = BW'(RPT_BYTES);

  logic          sclk_s, sdi_s, rise, fall, eop, byte_done;
  logic [2:0]    bit_idx;
  logic [BW-1:0] byte_cnt, done_idx, win_slot, done_win_slot, done_cmd_slot;
  logic [7:0]    rx_byte, code_q, tx_byte, done_rpt;
  logic [8*RPT_BYTES-1:0] rpt_q;
  logic [8*CMD_BYTES-1:0] cmd_q;
  logic [7:0]    rpt_in_b [RPT_BYTES];
  logic [7:0]    rpt_q_b  [RPT_BYTES];
  logic          in_win, first_bit;

  sbus_sync_edge #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .sclk_o(sclk_s), .sdi_o(sdi_s), .rise_o(rise), .fall_o(fall)
  );

  sbus_eop_det #(.LIMIT(EOP_BITS * BIT_CYC)) u_eop (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_s), .eop_o(eop)
  );

  sbus_framer #(.BYTE_MAX(TOT)) u_framer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(eop), .fall_i(fall), .sdi_i(sdi_s),
    .bit_idx_o(bit_idx), .byte_cnt_o(byte_cnt), .done_o(byte_done),
    .done_idx_o(done_idx), .byte_o(rx_byte)
  );

  for (genvar j = 0; j < RPT_BYTES; j++) begin : g_rpt
    assign rpt_in_b[j] = rpt_i[8*(RPT_BYTES-1-j) +: 8];
    assign rpt_q_b[j]  = rpt_q[8*(RPT_BYTES-1-j) +: 8];
  end

  assign win_slot      = byte_cnt - WIN_S_T;
  assign done_win_slot = done_idx - WIN_S_T;
  assign done_cmd_slot = done_idx - CMD_LO_T;
  assign in_win        = (win_slot <= K_T);
  assign first_bit     = (win_slot == '0) && (bit_idx == 3'd0);

  always_comb begin
    tx_byte  = code_q;
    done_rpt = '0;
    for (int j = 0; j < RPT_BYTES; j++) begin
      if (win_slot == BW'(j)) tx_byte = first_bit ? rpt_in_b[j] : rpt_q_b[j];
      if (done_win_slot == BW'(j)) done_rpt = rpt_q_b[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q      <= CHK_INIT;
      cmd_q       <= '0;
      cmd_o       <= '0;
      cmd_valid_o <= 1'b0;
      sdo_oe_o    <= 1'b0;
      sdo_o       <= 1'b0;
      rpt_q       <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (eop) begin
        // framing reset outranks any window activity
        code_q   <= CHK_INIT;
        sdo_oe_o <= 1'b0;
        sdo_o    <= 1'b0;
      end else begin
        if (rise && in_win) begin
          sdo_oe_o <= 1'b1;
          sdo_o    <= tx_byte[3'd7 - bit_idx];
          if (first_bit) rpt_q <= rpt_i;
        end
        if (byte_done) begin
          if (done_idx < BCAST_T) begin
            code_q <= chk_step(code_q, rx_byte);
            for (int j = 0; j < CMD_BYTES; j++)
              if (done_cmd_slot == BW'(j)) cmd_q[8*(CMD_BYTES-1-j) +: 8] <= rx_byte;
          end else if (done_idx == BCAST_T) begin
            if (rx_byte == code_q) begin
              cmd_o       <= cmd_q;
              cmd_valid_o <= 1'b1;
            end
            code_q <= CHK_INIT;
          end else if (done_win_slot < K_T) begin
            code_q <= chk_step(code_q, done_rpt);
          end
          if (done_win_slot == K_T) begin
            sdo_oe_o <= 1'b0;
            sdo_o    <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sbus_node_chk.sv
module sbus_node_chk #(
  parameter int BW = 5,
  parameter int CW = 32,
  parameter int KW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sdo_o,
  input logic          sdo_oe_o,
  input logic          cmd_valid_o,
  input logic [CW-1:0] cmd_o,
  input logic          rise_i,
  input logic          eop_i,
  input logic          done_i,
  input logic [BW-1:0] win_slot_i
);
  a_r3_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  a_r4_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_o) |-> cmd_valid_o);

  a_r5_oe_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> (win_slot_i <= BW'(KW + 1)));

  a_r5_sdo_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);

  a_r6_sdo_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> ($past(rise_i) || $past(eop_i) || $past(done_i)));

  a_r8_eop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_i |=> !sdo_oe_o);
endmodule

bind sbus_node sbus_node_chk #(.BW(BW), .CW(8*CMD_BYTES), .KW(RPT_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .cmd_valid_o(cmd_valid_o), .cmd_o(cmd_o), .rise_i(rise), .eop_i(eop),
  .done_i(byte_done), .win_slot_i(win_slot)
);

// File: tb/sbus_node_test.sv
module sbus_node_test;
  localparam int N = 3, M = 2, K = 2, IDX = 1, BC = 16, EB = 16;
  localparam int NB = N * M;
  localparam int WS = NB + 1 + IDX * (K + 1);
  localparam int WE = WS + K;
  localparam int EOP_CYC = EB * BC;

  logic clk = 0, rst_n = 0, sclk = 0, mdrv = 0;
  logic [15:0] rpt = '0;
  logic sdo, oe, valid;
  logic [15:0] cmd;
  wire sdi = oe ? sdo : mdrv;

  int checks = 0, errors = 0, vcount = 0;
  bit finished = 0;

  sbus_node #(.N_NODES(N), .CMD_BYTES(M), .RPT_BYTES(K), .NODE_IDX(IDX),
              .BIT_CYC(BC), .EOP_BITS(EB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .rpt_i(rpt),
    .sdo_o(sdo), .sdo_oe_o(oe), .cmd_o(cmd), .cmd_valid_o(valid)
  );

  always #4 clk = ~clk;
  always @(posedge clk) if (valid) vcount++;

  function automatic logic [7:0] hstep(input logic [7:0] c, input logic [7:0] d);
    int x;
    x = int'(c ^ d);
    return 8'((x * 167 + 59) % 256);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic b, output logic s, output logic o);
    @(negedge clk); sclk = 1; mdrv = b;
    repeat (BC/2 - 1) @(negedge clk);
    s = sdo; o = oe;
    @(negedge clk); sclk = 0;
    repeat (BC/2 - 1) @(negedge clk);
  endtask

  task automatic idle(input int n);
    sclk = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run_packet(input logic [7:0] mb [NB], input bit bad, input logic [15:0] r,
                            input int nbytes, input int pause_at, input bit swap);
    logic [7:0] h, tx, rx, e0, e1, e2, expb;
    logic s, o;
    bit oe_ok, exp_oe;
    int v0;
    v0 = vcount;
    rpt = r;
    h = 8'hAA;
    for (int i = 0; i < NB; i++) h = hstep(h, mb[i]);
    if (bad) h = h ^ 8'h5A;
    e0 = r[15:8]; e1 = r[7:0]; e2 = hstep(hstep(8'hAA, e0), e1);
    for (int i = 0; i < nbytes; i++) begin
      if (i == pause_at) idle(10 * BC);
      if (swap && i == WS + 1) rpt = ~r;
      tx = (i < NB) ? mb[i] : (i == NB) ? h : 8'(i * 29 + 3);
      exp_oe = (i >= WS && i <= WE);
      rx = '0; oe_ok = 1;
      for (int b = 0; b < 8; b++) begin
        bit_cycle(tx[7-b], s, o);
        rx = {rx[6:0], s};
        if (o !== exp_oe) oe_ok = 0;
      end
      check(oe_ok, "R5 enable per byte", int'(!exp_oe), int'(exp_oe));
      if (exp_oe) begin
        expb = (i == WS) ? e0 : (i == WS + 1) ? e1 : e2;
        check(rx == expb, (i == WE) ? "R7 reply check byte" :
              (swap ? "R10 latched report byte" : "R6 report byte"), rx, expb);
      end
    end
    idle(EOP_CYC + 2 * BC);
    if (nbytes > NB)
      check(vcount - v0 == (bad ? 0 : 1), bad ? "R4 no strobe" : "R3 one strobe",
            vcount - v0, bad ? 0 : 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] mb [NB];
    logic [15:0] exp_cmd;
    repeat (3) @(negedge clk);
    check(oe == 0 && sdo == 0, "R1 line idle", {oe, sdo}, 0);
    check(cmd == 0 && valid == 0, "R1 command clear", {cmd, valid}, 0);
    rst_n = 1;
    idle(20);

    // R2 R3 good packet, incrementing data
    for (int i = 0; i < NB; i++) mb[i] = 8'(8'h10 + i);
    run_packet(mb, 0, 16'hA55A, N*M + 1 + N*(K+1), -1, 0);
    exp_cmd = {mb[IDX*M], mb[IDX*M+1]};
    check(cmd == exp_cmd, "R2 captured commands", cmd, exp_cmd);

    // R4 corrupted check byte
    for (int i = 0; i < NB; i++) mb[i] = 8'(8'hC3 ^ (i * 17));
    run_packet(mb, 1, 16'h1234, 16, -1, 0);
    check(cmd == exp_cmd, "R4 command held", cmd, exp_cmd);

    // R9 all-ones data with a long but sub-threshold pause
    for (int i = 0; i < NB; i++) mb[i] = 8'hFF;
    run_packet(mb, 0, 16'h0000, 16, 4, 0);
    exp_cmd = 16'hFFFF;
    check(cmd == exp_cmd, "R9 pause tolerated", cmd, exp_cmd);

    // R8 truncate just after first window byte
    for (int i = 0; i < NB; i++) mb[i] = 8'(i * 3);
    run_packet(mb, 0, 16'h8001, WS + 1, -1, 0);
    check(oe == 0, "R8 enable released", oe, 0);

    // R8 R10 resync, all-zero data, report changed mid-window
    for (int i = 0; i < NB; i++) mb[i] = 8'h00;
    run_packet(mb, 0, 16'h3CC3, 16, -1, 1);
    check(cmd == 16'h0000, "R8 resync command", cmd, 0);

    // sweep of data and report patterns
    for (int s = 0; s < 6; s++) begin
      for (int i = 0; i < NB; i++) mb[i] = 8'(s * 37 + i * 91 + 1);
      run_packet(mb, (s == 3), 16'(s * 4099 + 77), 16, -1, 0);
      if (s != 3) exp_cmd = {mb[IDX*M], mb[IDX*M+1]};
      check(cmd == exp_cmd, "R2 sweep commands", cmd, exp_cmd);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule